// File: doc/BRIEF.md
# Transmit Test Pattern Inserter

This block decides which bit goes out on a serial transmit data line. It passes user data through or replaces it with a constant pattern or a pseudo-random test sequence. A 2-bit pattern code and a clock-source select bit together pick the source. Code 00 is shared: it means normal data with one clock source and all zeros with the other.

The pseudo-random source has two variants. In T1/J1 mode it is a 2^20-1 sequence with long zero runs suppressed. In E1 mode it is a plain 2^15-1 sequence. Either variant can be sent complemented.

The block runs in one clock domain. A bit-enable strobe marks each bit time, so the strobe can model pacing from either the line transmit clock or a master clock. Each new output bit is registered on a strobe edge. A change of the T1/E1 mode input reseeds the generator.

Top module: `tx_pattern_inserter`

## Requirements
- R1: With `clkSel`=0 and `patSel`=00, every bit-enable edge loads `userData` into `txData`.
- R2: With `clkSel`=1 and `patSel`=00, every bit-enable edge loads 0 into `txData`, whatever `userData` is.
- R3: With `patSel`=01, every bit-enable edge loads 1 into `txData`, for either value of `clkSel`.
- R4: With `patSel`=11, the block passes `userData` as in R1, for either value of `clkSel`.
- R5: With `patSel`=10 and `t1Mode`=0, the output is a Fibonacci LFSR sequence with period 32767.
  - The state is s[14:0]. The bit sent is s[14], so the MSB goes first.
  - After each bit, the state becomes {s[13:0], s[14]^s[13]}.
  - The E1 seed defaults to all ones.
- R6: With `patSel`=10 and `t1Mode`=1, the raw bit comes from a 20-bit register s[19:0], with period 2^20-1.
  - The raw bit is s[19].
  - After each bit, the state becomes {s[18:0], s[19]^s[16]}.
  - The T1 seed is a parameter.
- R7: In T1/J1 mode, a raw 0 that would follow 14 consecutive generated zeros is sent as 1, and the zero count restarts. The count runs on generated bits before inversion.
- R8: With `invertPrbs`=1, every pseudo-random bit is sent complemented, after zero limiting.
- R9: `txData` and the generator change only on clock edges where `bitEn`=1. The generator advances only on strobes while `patSel`=10 and holds its place under the other codes.
- R10: Reset drives `txData` to 0, loads the E1 seed and clears the zero count. The generator state is never all zeros.
- R11: At the first edge after `t1Mode` changes, the generator loads the seed of the new mode and clears its zero count. On that same edge `txData` holds even if `bitEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle strobe per transmitted bit |
| userData | input | 1 | Normal transmit data bit |
| patSel | input | 2 | Pattern code: 00 normal/zeros, 01 ones, 10 pseudo-random, 11 normal |
| clkSel | input | 1 | Clock-source select; with code 00, 1 selects all zeros |
| t1Mode | input | 1 | 1: 2^20-1 zero-limited sequence, 0: 2^15-1 sequence |
| invertPrbs | input | 1 | Complement the pseudo-random bits |
| txData | output | 1 | Registered serial transmit bit |

## Verification
The user-data codes are driven with an irregular bit pattern. This tells a true pass-through apart from a constant or a delayed copy.

The constant codes are driven with user data opposite to the expected constant, under both clock-select values. This separates the shared 00 code's two meanings.

The E1 sequence is compared bit by bit against an arithmetic model for a full period plus 64 bits. This shows both the taps and the wrap length.

A T1 seed that begins a 19-zero raw run exposes the forced one at bit 15. Strobe gaps and pattern switches mid-sequence show that the generator holds its place. Mode toggles with the strobe held high show the reseed and the held output.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

  typedef enum logic [1:0] {
    SRC_USER = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_ONE  = 2'd2,
    SRC_PRBS = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    loadSeed;
    logic    advance;
    logic    shift;
    srcSel_e src;
  } tpiStrobe_t;

endpackage

// File: rtl/tpi_prbs_gen.sv
module tpi_prbs_gen #(
  parameter int T1_LEN       = 20,
  parameter int T1_TAP       = 17,
  parameter int E1_LEN       = 15,
  parameter int E1_TAP       = 14,
  parameter int MAX_ZERO_RUN = 14,
  parameter logic [T1_LEN-1:0] T1_SEED = '1,
  parameter logic [E1_LEN-1:0] E1_SEED = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic t1Mode,
  input  logic loadSeed,
  input  logic advance,
  output logic genBit
);

  localparam int REG_W = T1_LEN;
  localparam int CNT_W = $clog2(MAX_ZERO_RUN + 1);
  localparam logic [REG_W-1:0] E1_MASK = {{(REG_W-E1_LEN){1'b0}}, {E1_LEN{1'b1}}};
  localparam logic [REG_W-1:0] T1_INIT = REG_W'(T1_SEED);
  localparam logic [REG_W-1:0] E1_INIT = REG_W'(E1_SEED);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(MAX_ZERO_RUN);

  logic [REG_W-1:0] lfsr;
  logic [REG_W-1:0] lfsrNext;
  logic [CNT_W-1:0] zeroRun;
  logic rawBit;
  logic fbBit;
  logic forceOne;

  always_comb begin
    if (t1Mode) begin
      rawBit = lfsr[T1_LEN-1];
      fbBit  = lfsr[T1_LEN-1] ^ lfsr[T1_TAP-1];
    end else begin
      rawBit = lfsr[E1_LEN-1];
      fbBit  = lfsr[E1_LEN-1] ^ lfsr[E1_TAP-1];
    end
    forceOne = t1Mode && !rawBit && (zeroRun == RUN_MAX);
    genBit   = rawBit | forceOne;
    lfsrNext = {lfsr[REG_W-2:0], fbBit};
    if (!t1Mode) lfsrNext = lfsrNext & E1_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr    <= E1_INIT;
      zeroRun <= '0;
    end else if (loadSeed) begin
      lfsr    <= t1Mode ? T1_INIT : E1_INIT;
      zeroRun <= '0;
    end else if (advance) begin
      lfsr <= lfsrNext;
      if (genBit)                zeroRun <= '0;
      else if (zeroRun != RUN_MAX) zeroRun <= zeroRun + 1'b1;
    end
  end

  // R10: the generator never sits in the lock-up state
  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  // R7: the zero run never passes the limit in T1/J1 mode
  a_r7_run_bounded: assert property (@(posedge clk) disable iff (!rstN)
    t1Mode |-> zeroRun <= RUN_MAX);

  // R11: a reload lands the seed of the mode that requested it
  a_r11_seed_loaded: assert property (@(posedge clk) disable iff (!rstN)
    loadSeed |=> lfsr == ($past(t1Mode) ? T1_INIT : E1_INIT));

  // R9: without an advance or a reload the sequence position holds
  a_r9_gen_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !loadSeed) |=> $stable(lfsr) && $stable(zeroRun));

endmodule

// File: rtl/tpi_ctrl.sv
module tpi_ctrl
  import tpi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] patSel,
  input  logic       clkSel,
  input  logic       t1Mode,
  output tpiStrobe_t strobe
);

  logic modeQ;
  logic modeChange;
  srcSel_e src;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= 1'b0;
    else       modeQ <= t1Mode;
  end

  assign modeChange = t1Mode != modeQ;

  always_comb begin
    unique case (patSel)
      2'b00:   src = clkSel ? SRC_ZERO : SRC_USER;
      2'b01:   src = SRC_ONE;
      2'b10:   src = SRC_PRBS;
      default: src = SRC_USER;
    endcase
    strobe.src      = src;
    strobe.loadSeed = modeChange;
    strobe.shift    = bitEn && !modeChange;
    strobe.advance  = bitEn && !modeChange && (src == SRC_PRBS);
  end

  // R11: the registered mode tracks the input one cycle later
  a_r11_mode_tracked: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> modeQ == $past(t1Mode));

endmodule

// File: rtl/tpi_datapath.sv
module tpi_datapath
  import tpi_pkg::*;
#(
  parameter int T1_LEN       = 20,
  parameter int T1_TAP       = 17,
  parameter int E1_LEN       = 15,
  parameter int E1_TAP       = 14,
  parameter int MAX_ZERO_RUN = 14,
  parameter logic [T1_LEN-1:0] T1_SEED = '1,
  parameter logic [E1_LEN-1:0] E1_SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  tpiStrobe_t strobe,
  input  logic       t1Mode,
  input  logic       userData,
  input  logic       invertPrbs,
  output logic       txData
);

  logic genBit;
  logic nextBit;

  tpi_prbs_gen #(
    .T1_LEN(T1_LEN), .T1_TAP(T1_TAP),
    .E1_LEN(E1_LEN), .E1_TAP(E1_TAP),
    .MAX_ZERO_RUN(MAX_ZERO_RUN),
    .T1_SEED(T1_SEED), .E1_SEED(E1_SEED)
  ) gen_i (
    .clk(clk),
    .rstN(rstN),
    .t1Mode(t1Mode),
    .loadSeed(strobe.loadSeed),
    .advance(strobe.advance),
    .genBit(genBit)
  );

  always_comb begin
    unique case (strobe.src)
      SRC_USER: nextBit = userData;
      SRC_ZERO: nextBit = 1'b0;
      SRC_ONE:  nextBit = 1'b1;
      default:  nextBit = genBit ^ invertPrbs;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txData <= 1'b0;
    else if (strobe.shift) txData <= nextBit;
  end

  // R1/R4: user data reaches the line one edge after its strobe
  a_r1_user_passed: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && strobe.src == SRC_USER) |=> txData == $past(userData));

  // R2: the shared zero code blanks the line
  a_r2_zeros_sent: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && strobe.src == SRC_ZERO) |=> !txData);

  // R3: the ones code drives the line high
  a_r3_ones_sent: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && strobe.src == SRC_ONE) |=> txData);

  // R9: no strobe, no change on the line
  a_r9_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(txData));

endmodule

// File: rtl/tx_pattern_inserter.sv
module tx_pattern_inserter
  import tpi_pkg::*;
#(
  parameter int T1_LEN       = 20,
  parameter int T1_TAP       = 17,
  parameter int E1_LEN       = 15,
  parameter int E1_TAP       = 14,
  parameter int MAX_ZERO_RUN = 14,
  parameter logic [T1_LEN-1:0] T1_SEED = '1,
  parameter logic [E1_LEN-1:0] E1_SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       userData,
  input  logic [1:0] patSel,
  input  logic       clkSel,
  input  logic       t1Mode,
  input  logic       invertPrbs,
  output logic       txData
);

  tpiStrobe_t strobe;

  tpi_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .bitEn(bitEn),
    .patSel(patSel),
    .clkSel(clkSel),
    .t1Mode(t1Mode),
    .strobe(strobe)
  );

  tpi_datapath #(
    .T1_LEN(T1_LEN), .T1_TAP(T1_TAP),
    .E1_LEN(E1_LEN), .E1_TAP(E1_TAP),
    .MAX_ZERO_RUN(MAX_ZERO_RUN),
    .T1_SEED(T1_SEED), .E1_SEED(E1_SEED)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .t1Mode(t1Mode),
    .userData(userData),
    .invertPrbs(invertPrbs),
    .txData(txData)
  );

endmodule

// File: tb/tx_pattern_inserter_tb.sv
module tx_pattern_inserter_tb_top;

  localparam logic [19:0] T1S = 20'h00001;
  localparam logic [14:0] E1S = 15'h7FFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic userData = 1'b0;
  logic [1:0] patSel = 2'b00;
  logic clkSel = 1'b0;
  logic t1Mode = 1'b0;
  logic invertPrbs = 1'b0;
  logic txData;

  int checks = 0;
  int errors = 0;

  logic [19:0] mS;
  int mRun;
  logic mT1;
  logic mInv;
  logic firstBits [64];

  always #2 clk = ~clk;

  tx_pattern_inserter #(.T1_SEED(T1S), .E1_SEED(E1S)) dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .userData(userData),
    .patSel(patSel), .clkSel(clkSel), .t1Mode(t1Mode),
    .invertPrbs(invertPrbs), .txData(txData)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: txData=%0b expected %0b", req, act, exp);
    end
  endtask

  // inputs change at a negedge; sample at the following negedge
  task automatic step(input logic en, input logic u);
    bitEn = en;
    userData = u;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic modelStep(output logic bitOut);
    logic raw, g, fb;
    raw = mT1 ? mS[19] : mS[14];
    g = raw | (mT1 && !raw && mRun == 14);
    bitOut = g ^ mInv;
    if (g) mRun = 0;
    else if (mRun < 14) mRun = mRun + 1;
    fb = mT1 ? (mS[19] ^ mS[16]) : (mS[14] ^ mS[13]);
    mS = {mS[18:0], fb};
    if (!mT1) mS[19:15] = 5'b0;
  endtask

  function automatic logic pat(input int i);
    return 1'(((i * 37) >> 2) ^ (i / 5));
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic e, prev;
    int z;
    mS = {5'b0, E1S}; mRun = 0; mT1 = 1'b0; mInv = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txData, 1'b0, "R10 reset");

    // R1 normal data
    patSel = 2'b00; clkSel = 1'b0;
    for (int i = 0; i < 32; i++) begin
      step(1'b1, pat(i)); chk(txData, pat(i), "R1 pass-through");
    end
    // R2 all zeros
    clkSel = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'(~i[0] | pat(i))); chk(txData, 1'b0, "R2 zeros");
    end
    // R3 all ones, both clock selects
    patSel = 2'b01;
    for (int i = 0; i < 16; i++) begin
      clkSel = i[0]; step(1'b1, 1'b0); chk(txData, 1'b1, "R3 ones");
    end
    // R4 code 11 passes data
    patSel = 2'b11;
    for (int i = 0; i < 32; i++) begin
      clkSel = i[1]; step(1'b1, pat(i + 7)); chk(txData, pat(i + 7), "R4 code11");
    end
    // R9 strobe low holds
    patSel = 2'b01; step(1'b1, 1'b0); chk(txData, 1'b1, "R3 ones");
    patSel = 2'b00; clkSel = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0); chk(txData, 1'b1, "R9 hold without strobe");
    end
    step(1'b1, 1'b1); chk(txData, 1'b0, "R2 zeros");

    // R5 E1 sequence over a full period
    patSel = 2'b10; clkSel = 1'b0;
    for (int n = 0; n < 32767 + 64; n++) begin
      modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R5 E1 sequence");
      if (n < 64) firstBits[n] = txData;
      if (n >= 32767) chk(txData, firstBits[n - 32767], "R5 period");
    end
    // R9 gaps and pattern switches keep the position
    prev = txData;
    for (int n = 0; n < 200; n++) begin
      if (n % 3 != 0) begin
        modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R9 gapped strobe");
        prev = e;
      end else begin
        step(1'b0, 1'b1); chk(txData, prev, "R9 gap hold");
      end
      if (n == 100) begin
        patSel = 2'b01;
        for (int k = 0; k < 4; k++) begin
          step(1'b1, 1'b0); chk(txData, 1'b1, "R3 ones");
        end
        patSel = 2'b10;
      end
    end
    // R8 inversion in E1
    invertPrbs = 1'b1; mInv = 1'b1;
    for (int n = 0; n < 100; n++) begin
      modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R8 E1 inverted");
    end
    invertPrbs = 1'b0; mInv = 1'b0;

    // R11 switch to T1 with strobe high
    prev = txData;
    t1Mode = 1'b1; step(1'b1, 1'b0); chk(txData, prev, "R11 hold on mode change");
    mT1 = 1'b1; mS = T1S; mRun = 0;
    z = 0;
    for (int n = 0; n < 3000; n++) begin
      modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R6 T1 sequence");
      if (n < 14) chk(txData, 1'b0, "R6 seed zeros");
      if (n == 14) chk(txData, 1'b1, "R7 forced one");
      z = txData ? 0 : z + 1;
      chk(z <= 14, 1'b1, "R7 zero run limit");
    end
    // R8 inversion in T1
    invertPrbs = 1'b1; mInv = 1'b1;
    for (int n = 0; n < 200; n++) begin
      modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R8 T1 inverted");
    end
    invertPrbs = 1'b0; mInv = 1'b0;

    // R11 back to E1 reseeds
    prev = txData;
    t1Mode = 1'b0; step(1'b1, 1'b0); chk(txData, prev, "R11 hold on mode change");
    mT1 = 1'b0; mS = {5'b0, E1S}; mRun = 0;
    for (int n = 0; n < 100; n++) begin
      modelStep(e); step(1'b1, 1'b0); chk(txData, e, "R11 E1 reseed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule